// File: doc/BRIEF.md
# In-Order Retire Slot Queue

This block keeps instructions in program order from dispatch to retirement. It is a ring of retire slots. A reservation takes as many consecutive slots as the instruction has micro-ops. A micro-op count of zero still takes one slot, and a count larger than the ring takes exactly the whole ring. The caller gets back a token, which is the slot index where the new entry starts. Completion notices arrive later, one per cycle, carrying that token, and they may come in any order.

Each cycle the oldest entries that have completed are offered on a bank of retire lanes, oldest on lane 0. The offer stops at the first entry that has not completed, or when the ring runs out of entries. A per-cycle cap limits how many lanes are used, and a cap of 0 means all lanes.

Both data flows use valid/ready handshakes. A reservation is accepted in a cycle where `rsv_valid` and `rsv_ready` are both high. While `rsv_ready` is low the caller holds its request, and no state changes. The retire lanes show their contents whether or not `ret_ready` is high. Everything shown leaves only in a cycle where `ret_ready` is high. When `ret_ready` is low, the shown entries stay at the head and are offered again. The completion port and the cap are plain control inputs, and the free-slot count is a plain status output.

Top module: `rq_retire_queue`

## Requirements
- R1: After reset, `free_slots` equals DEPTH, no retire lane is valid, `rsv_token` is 0 and the ring is empty.
- R2: A reservation takes `max(1, min(rsv_uops, DEPTH))` slots. A count of 0 takes one slot, and a count above DEPTH takes all DEPTH slots.
- R3: `rsv_token` always shows the write position, which is where the next entry will start. After an accepted reservation, the write position advances by the slot quantity, wrapping modulo DEPTH.
- R4: `rsv_ready` is high exactly when `free_slots` is at least the slot quantity of the offered request. While it is low, the request is not taken and `rsv_token` does not move.
- R5: `free_slots` drops by the reserved quantity on an accepted reservation and rises by the slot counts of the entries retired. When both happen in one cycle, both changes apply. Readiness in that cycle counts only the slots that were free at the start of the cycle. `free_slots` never exceeds DEPTH.
- R6: A completion notice whose token is the start slot of a pending entry marks that entry done. The entry can be offered for retirement from the next cycle on. Notices may arrive in any order.
- R7: A completion notice is ignored in three cases: its token is not the start slot of a live entry, its entry is already done, or its token is DEPTH or above.
- R8: Retire lanes are filled from lane 0 upward with no gaps, in program order starting at the head. The fill stops at the first entry that is not done or when no entry remains. Each valid lane carries the ID given at reservation.
- R9: The number of valid lanes is at most `ret_cap`. A `ret_cap` of 0, or any value above LANES, allows all LANES lanes.
- R10: While `ret_ready` is low, nothing retires. The lanes keep showing the same head entry, and `free_slots` does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsv_valid | input | 1 | Reservation request valid |
| rsv_ready | output | 1 | Enough free slots for the offered request |
| rsv_id | input | ID_W | Instruction ID stored with the entry |
| rsv_uops | input | UOP_W | Micro-op count of the instruction |
| rsv_token | output | $clog2(DEPTH) | Start slot the request gets if accepted |
| exe_valid | input | 1 | Completion notice valid |
| exe_token | input | $clog2(DEPTH) | Token of the completed entry |
| ret_valid | output | LANES | Per-lane retire valid, contiguous from lane 0 |
| ret_ready | input | 1 | Consumer takes all valid lanes this cycle |
| ret_id | output | LANES x ID_W | Instruction ID per retire lane |
| ret_cap | input | $clog2(LANES+1) | Per-cycle retire cap, 0 for no cap |
| free_slots | output | $clog2(DEPTH+1) | Number of unreserved slots |

## Verification
The case that needs care is a reservation and a retirement landing in the same cycle. The free count must take both changes, while readiness must ignore the slots being freed in that cycle. This is provoked by keeping the ring close to full while requests of several sizes are offered. Completions are sent so that the head becomes ready, and `ret_ready` is toggled. The result is judged by comparing `rsv_ready`, `rsv_token` and `free_slots` against the reference model in every cycle. In the model, the retired slots return only after the reservation decision has been made.

// File: rtl/rq_pkg.sv
package rq_pkg;

  // Add two ring positions and fold the result back into [0, n).
  // Both operands are below n, so one subtraction is enough.
  function automatic int wrap_int(int a, int b, int n);
    int s;
    s = a + b;
    if (s >= n) s = s - n;
    return s;
  endfunction

  // Number of lanes usable this cycle; 0 or an over-range cap opens all lanes.
  function automatic int lane_limit(int cap, int lanes);
    return (cap == 0 || cap > lanes) ? lanes : cap;
  endfunction

endpackage

// File: rtl/rq_alloc.sv
module rq_alloc #(
  parameter int DEPTH = 32,
  parameter int UOP_W = 6,
  parameter int PW    = 5,
  parameter int CW    = 6
) (
  input  logic [UOP_W-1:0] uops,
  input  logic [CW-1:0]    free_cnt,
  input  logic [PW-1:0]    wr_ptr,
  output logic [CW-1:0]    qty,
  output logic             fits,
  output logic [PW-1:0]    wr_next
);
  localparam int XW = (UOP_W > CW) ? UOP_W : CW;

  logic [XW-1:0] ext;
  assign ext = XW'(uops);

  // Slot quantity: at least one slot, at most the whole ring.
  always_comb begin
    if (ext == '0)
      qty = CW'(1);
    else if (ext > XW'(DEPTH))
      qty = CW'(DEPTH);
    else
      qty = ext[CW-1:0];
  end

  assign fits    = (qty <= free_cnt);
  assign wr_next = PW'(rq_pkg::wrap_int(int'(wr_ptr), int'(qty), DEPTH));

endmodule

// File: rtl/rq_slot_store.sv
module rq_slot_store #(
  parameter int DEPTH = 32,
  parameter int ID_W  = 8,
  parameter int PW    = 5,
  parameter int CW    = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [PW-1:0]               wr_idx,
  input  logic [ID_W-1:0]             wr_id,
  input  logic [CW-1:0]               wr_qty,
  input  logic                        exe_en,
  input  logic [PW-1:0]               exe_idx,
  input  logic [DEPTH-1:0]            clr_mask,
  output logic [DEPTH-1:0]            live,
  output logic [DEPTH-1:0]            done,
  output logic [DEPTH-1:0][ID_W-1:0]  ids,
  output logic [DEPTH-1:0][CW-1:0]    cnts
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit_wr, hit_exe;
    assign hit_wr  = wr_en  && (wr_idx  == PW'(g));
    assign hit_exe = exe_en && (exe_idx == PW'(g));

    // Entry state: a start slot is live until retired, done once completed.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live[g] <= 1'b0;
        done[g] <= 1'b0;
      end else if (hit_wr) begin
        live[g] <= 1'b1;
        done[g] <= 1'b0;
      end else if (clr_mask[g]) begin
        live[g] <= 1'b0;
        done[g] <= 1'b0;
      end else if (hit_exe && live[g] && !done[g]) begin
        done[g] <= 1'b1;
      end
    end

    // Payload needs no reset: it is only read while the slot is live.
    always_ff @(posedge clk) begin
      if (hit_wr) begin
        ids[g]  <= wr_id;
        cnts[g] <= wr_qty;
      end
    end
  end

  // R6
  exe_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_en && live[exe_idx] && !done[exe_idx]) |=> done[$past(exe_idx)]);

  // R7
  exe_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_en && !live[exe_idx] && !(wr_en && wr_idx == exe_idx))
      |=> !done[$past(exe_idx)]);

  // R3
  rsv_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (live[$past(wr_idx)] && !done[$past(wr_idx)]));

endmodule

// File: rtl/rq_retire_scan.sv
module rq_retire_scan #(
  parameter int DEPTH = 32,
  parameter int ID_W  = 8,
  parameter int LANES = 4,
  parameter int PW    = 5,
  parameter int CW    = 6,
  parameter int LW    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [PW-1:0]               head,
  input  logic [CW-1:0]               used,
  input  logic [LW-1:0]               cap,
  input  logic                        fire,
  input  logic [DEPTH-1:0]            live,
  input  logic [DEPTH-1:0]            done,
  input  logic [DEPTH-1:0][ID_W-1:0]  ids,
  input  logic [DEPTH-1:0][CW-1:0]    cnts,
  output logic [LANES-1:0]            lane_vld,
  output logic [LANES-1:0][ID_W-1:0]  lane_id,
  output logic [DEPTH-1:0]            clr_mask,
  output logic [CW-1:0]               freed
);
  int lane_lim;
  assign lane_lim = rq_pkg::lane_limit(int'(cap), LANES);

  // Walk entries from the head. Each lane steps over the slots of the
  // previous entry, and the chain breaks at the first entry not ready.
  always_comb begin
    logic [PW-1:0] p;
    logic [CW-1:0] acc;
    logic          go;
    p        = head;
    acc      = '0;
    go       = 1'b1;
    lane_vld = '0;
    lane_id  = '0;
    clr_mask = '0;
    for (int k = 0; k < LANES; k++) begin
      go = go && (k < lane_lim) && (acc < used) && live[p] && done[p];
      if (go) begin
        lane_vld[k] = 1'b1;
        lane_id[k]  = ids[p];
        clr_mask[p] = fire;
        acc         = acc + cnts[p];
        p           = PW'(rq_pkg::wrap_int(int'(p), int'(cnts[p]), DEPTH));
      end
    end
    freed = fire ? acc : '0;
  end

  // R8
  lane_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_vld + 1'b1) & lane_vld) == '0);

  // R9
  lane_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_vld) <= lane_lim);

endmodule

// File: rtl/rq_retire_queue.sv
module rq_retire_queue #(
  parameter int DEPTH = 32,
  parameter int ID_W  = 8,
  parameter int UOP_W = 6,
  parameter int LANES = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int LW   = $clog2(LANES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rsv_valid,
  output logic                       rsv_ready,
  input  logic [ID_W-1:0]            rsv_id,
  input  logic [UOP_W-1:0]           rsv_uops,
  output logic [PW-1:0]              rsv_token,
  input  logic                       exe_valid,
  input  logic [PW-1:0]              exe_token,
  output logic [LANES-1:0]           ret_valid,
  input  logic                       ret_ready,
  output logic [LANES-1:0][ID_W-1:0] ret_id,
  input  logic [LW-1:0]              ret_cap,
  output logic [CW-1:0]              free_slots
);
  localparam logic [PW:0]   DEPTH_P = (PW + 1)'(DEPTH);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [PW-1:0] wr_ptr, head_ptr, wr_next;
  logic [CW-1:0] free_q, qty, freed, used;
  logic          fits, rsv_fire, exe_en, ret_fire;

  logic [DEPTH-1:0]           live, done, clr_mask;
  logic [DEPTH-1:0][ID_W-1:0] ids;
  logic [DEPTH-1:0][CW-1:0]   cnts;

  rq_alloc #(.DEPTH(DEPTH), .UOP_W(UOP_W), .PW(PW), .CW(CW)) u_alloc (
    .uops(rsv_uops), .free_cnt(free_q), .wr_ptr(wr_ptr),
    .qty(qty), .fits(fits), .wr_next(wr_next)
  );

  assign rsv_ready = fits;
  assign rsv_fire  = rsv_valid && fits;
  assign rsv_token = wr_ptr;
  assign exe_en    = exe_valid && ({1'b0, exe_token} < DEPTH_P);
  assign ret_fire  = ret_ready;
  assign used      = DEPTH_C - free_q;

  rq_slot_store #(.DEPTH(DEPTH), .ID_W(ID_W), .PW(PW), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rsv_fire), .wr_idx(wr_ptr), .wr_id(rsv_id), .wr_qty(qty),
    .exe_en(exe_en), .exe_idx(exe_token), .clr_mask(clr_mask),
    .live(live), .done(done), .ids(ids), .cnts(cnts)
  );

  rq_retire_scan #(.DEPTH(DEPTH), .ID_W(ID_W), .LANES(LANES),
                   .PW(PW), .CW(CW), .LW(LW)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .head(head_ptr), .used(used), .cap(ret_cap), .fire(ret_fire),
    .live(live), .done(done), .ids(ids), .cnts(cnts),
    .lane_vld(ret_valid), .lane_id(ret_id),
    .clr_mask(clr_mask), .freed(freed)
  );

  // Pointers and free count. Readiness used free_q before this cycle's
  // retirements, so the two updates below never overlap in slots.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      head_ptr <= '0;
      free_q   <= DEPTH_C;
    end else begin
      if (rsv_fire) wr_ptr <= wr_next;
      head_ptr <= PW'(rq_pkg::wrap_int(int'(head_ptr), int'(freed), DEPTH));
      free_q   <= free_q - (rsv_fire ? qty : '0) + freed;
    end
  end

  assign free_slots = free_q;

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_slots <= DEPTH_C);

  // R4
  rsv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_valid && !rsv_ready) |=> (rsv_token == $past(rsv_token)));

  // R10
  ret_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid[0] && !ret_ready)
      |=> (ret_valid[0] && ret_id[0] == $past(ret_id[0])));

endmodule

// File: tb/tb_rq_retire_queue.sv
module tb_rq_retire_queue;
  localparam int DEPTH = 12;
  localparam int ID_W  = 8;
  localparam int UOP_W = 5;
  localparam int LANES = 4;
  localparam int PW    = 4;
  localparam int CW    = 4;
  localparam int LW    = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic rsv_valid, rsv_ready, exe_valid, ret_ready;
  logic [ID_W-1:0]  rsv_id;
  logic [UOP_W-1:0] rsv_uops;
  logic [PW-1:0]    rsv_token, exe_token;
  logic [LANES-1:0] ret_valid;
  logic [LANES-1:0][ID_W-1:0] ret_id;
  logic [LW-1:0]    ret_cap;
  logic [CW-1:0]    free_slots;

  always #4 clk = ~clk;

  rq_retire_queue #(.DEPTH(DEPTH), .ID_W(ID_W), .UOP_W(UOP_W), .LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n),
    .rsv_valid(rsv_valid), .rsv_ready(rsv_ready), .rsv_id(rsv_id),
    .rsv_uops(rsv_uops), .rsv_token(rsv_token),
    .exe_valid(exe_valid), .exe_token(exe_token),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_id(ret_id),
    .ret_cap(ret_cap), .free_slots(free_slots)
  );

  // Behavioural reference: an ordered list of pending instructions.
  typedef struct { int id; int qty; int tok; bit done; } ent_t;
  ent_t  mq[$];
  int    m_wr, m_free;
  int    n_chk = 0, n_bad = 0;
  bit    finished = 0;
  string phase = "R1";

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [phase %s] actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  function automatic int m_qty(int u);
    if (u == 0) return 1;
    if (u > DEPTH) return DEPTH;
    return u;
  endfunction

  function automatic int m_nret();
    int lim = (ret_cap == 0 || ret_cap > LANES) ? LANES : int'(ret_cap);
    int n = 0;
    while (n < lim && n < mq.size() && mq[n].done) n++;
    return n;
  endfunction

  task automatic compare();
    int n  = m_nret();
    int qe = m_qty(int'(rsv_uops));
    chk(rsv_ready == (m_free >= qe), "R4", rsv_ready, m_free >= qe);
    chk(int'(rsv_token) == m_wr, "R3", rsv_token, m_wr);
    chk(int'(free_slots) == m_free, "R5", free_slots, m_free);
    chk(int'(ret_valid) == (1 << n) - 1, "R8", ret_valid, (1 << n) - 1);
    for (int k = 0; k < n; k++)
      chk(int'(ret_id[k]) == mq[k].id, "R8", ret_id[k], mq[k].id);
  endtask

  task automatic model_step();
    int n  = m_nret();
    int qe = m_qty(int'(rsv_uops));
    bit ok = (m_free >= qe);
    if (exe_valid)
      foreach (mq[i])
        if (mq[i].tok == int'(exe_token) && !mq[i].done) begin
          mq[i].done = 1'b1;
          break;
        end
    if (ret_ready)
      for (int k = 0; k < n; k++) begin
        m_free += mq[0].qty;
        void'(mq.pop_front());
      end
    if (rsv_valid && ok) begin
      mq.push_back('{id: int'(rsv_id), qty: qe, tok: m_wr, done: 1'b0});
      m_free -= qe;
      m_wr = (m_wr + qe) % DEPTH;
    end
  endtask

  // Compare at negedge+1, advance the model right after the rising edge.
  task automatic tick();
    #1;
    compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    rsv_valid = 0; rsv_uops = '0; rsv_id = '0;
    exe_valid = 0; exe_token = '0;
    ret_ready = 1; ret_cap = '0;
  endtask

  task automatic rsv(int id, int u);
    rsv_valid = 1; rsv_id = ID_W'(id); rsv_uops = UOP_W'(u);
  endtask

  task automatic exe(int t);
    exe_valid = 1; exe_token = PW'(t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog [phase %s] actual=%0d expected=%0d", phase, 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    mq.delete(); m_wr = 0; m_free = DEPTH;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    #1;
    chk(free_slots == CW'(DEPTH), "R1", free_slots, DEPTH);
    chk(ret_valid == '0, "R1", ret_valid, 0);
    chk(rsv_token == '0, "R1", rsv_token, 0);
    tick();

    // R2: zero micro-ops take one slot; oversize takes the whole ring
    phase = "R2";
    rsv(1, 0); tick(); idle();
    #1; chk(free_slots == CW'(DEPTH - 1), "R2", free_slots, DEPTH - 1);
    chk(rsv_token == PW'(1), "R3", rsv_token, 1);
    exe(0); tick(); idle(); tick();
    rsv(2, 20); tick(); idle();
    #1; chk(free_slots == '0, "R2", free_slots, 0);
    chk(rsv_token == PW'(1), "R3", rsv_token, 1);

    // R4: full ring back-pressures a request, which is held
    phase = "R4";
    rsv(3, 1);
    #1; chk(rsv_ready == 1'b0, "R4", rsv_ready, 0);
    tick(); tick();
    exe(1); tick(); exe_valid = 0;
    tick(); tick(); idle(); tick();
    exe(1); tick(); idle(); tick(); tick();

    // R6: out-of-order completion does not bypass the head
    phase = "R6";
    rsv(4, 2); tick(); rsv(5, 3); tick(); rsv(6, 1); tick(); idle();
    exe(7); tick(); exe(4); tick(); idle();
    #1; chk(ret_valid == '0, "R6", ret_valid, 0);
    tick();

    // R7: notices to a mid-entry slot, a done entry, or out of range
    phase = "R7";
    exe(3); tick(); exe(7); tick(); exe(14); tick(); idle();
    #1; chk(ret_valid == '0, "R7", ret_valid, 0);
    chk(free_slots == CW'(DEPTH - 6), "R7", free_slots, DEPTH - 6);
    tick();

    // R10: consumer stall keeps entries at the head
    phase = "R10";
    ret_ready = 0; exe(2); tick(); exe_valid = 0;
    #1; chk(ret_valid == 4'b0111, "R10", ret_valid, 7);
    tick();
    #1; chk(ret_valid == 4'b0111, "R10", ret_valid, 7);
    chk(free_slots == CW'(DEPTH - 6), "R10", free_slots, DEPTH - 6);
    tick();

    // R9: per-cycle cap
    phase = "R9";
    ret_ready = 1; ret_cap = 1;
    #1; chk(ret_valid == 4'b0001, "R9", ret_valid, 1);
    tick();
    ret_cap = 2;
    #1; chk(ret_valid == 4'b0011, "R9", ret_valid, 3);
    tick(); idle(); tick();

    // R5 and R8: mixed random traffic, same-cycle reserve and retire
    phase = "R5";
    for (int c = 0; c < 4000; c++) begin
      int r = $urandom_range(0, 9);
      rsv_valid = (r < 7);
      rsv_id    = ID_W'($urandom_range(0, 255));
      rsv_uops  = (r == 0) ? UOP_W'($urandom_range(13, 20))
                           : UOP_W'($urandom_range(0, 5));
      exe_valid = ($urandom_range(0, 3) != 0);
      if (mq.size() > 0 && $urandom_range(0, 4) != 0)
        exe_token = PW'(mq[$urandom_range(0, mq.size() - 1)].tok);
      else
        exe_token = PW'($urandom_range(0, 15));
      ret_ready = ($urandom_range(0, 4) != 0);
      ret_cap   = LW'($urandom_range(0, 7));
      if (c == 2000) phase = "R8";
      tick();
    end

    // Drain
    phase = "R8";
    idle();
    for (int c = 0; c < 40; c++) begin
      if (mq.size() > 0) exe(mq[c % mq.size()].tok);
      else exe_valid = 0;
      tick();
    end
    idle();
    #1; chk(free_slots == CW'(DEPTH), "R5", free_slots, DEPTH);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule